// File: doc/BRIEF.md
# Protected Load Switch Startup Sequencer

This block decides when a protected load switch may conduct. It takes comparator results for the supply and output rails, plus two enable pins. When the supply is inside its window and the enables allow it, the block runs a debounce wait and then a gate turn-on wait. After that it requests the switch on.

While the switch is starting, the block asks the current limiter for a boosted multiple of the programmed limit for a short initial window. It also watches for the output to charge. If the output does not charge before a long startup timeout, the block turns the switch off and latches it off. The latch holds until an enable pin changes or the supply drops below its undervoltage level.

When the output charges in time, the block does three things. It emits a one-cycle completion strobe. It samples the current-limit mode pins. It then reports the selected mode.

All inputs are asynchronous levels. Each passes through a two-flop synchroniser before it is used. Every timer length is a parameter counted in clock ticks. All outputs are plain levels or strobes, with no handshake.

Top module: `psw_start_seq`

## Requirements
- R1: The enable pins decode as follows. With (en_hv, en_lv) = (1, 0) the switch is never requested. The pairs 00, 01 and 11 allow it. Entering the disallowed pair drops sw_on three clocks after the pins change.
- R2: A qualifying condition is supply above UVLO, supply not above OVLO, enables allowed and not latched. From a non-qualified state, sw_on rises exactly 3 + DEB_TICKS + GATE_TICKS clocks after the inputs become qualifying, when out_above_uv is low.
- R3: If the supply drops below UVLO during the debounce wait, the switch is not turned on. A later return of the supply restarts the full debounce from zero.
- R4: When out_above_uv is high as qualification begins, the debounce is skipped and sw_on rises 3 + GATE_TICKS clocks later. This includes the case of leaving overvoltage.
- R5: ilim_mult holds BOOST_CODE for STI_TICKS clocks starting with the first sw_on cycle, and 0 otherwise. The codes are 0 = 1x, 1 = 1.5x and 2 = 2x.
- R6: If out_charged is not seen within STO_TICKS clocks of sw_on rising, sw_on falls and latched_off rises in the same clock. The switch then stays off while latched.
- R7: latched_off clears three clocks after either enable pin changes level, or after the supply drops below UVLO. It does not clear otherwise.
- R8: A restart after a supply dropout runs the full startup again, including the timeout and latch.
- R9: lim_mode reads 2 (continuous) whenever startup has not completed. At completion, lim_mode takes the synchronised lim_sel pins: 00 gives 0 (latch-off), 01 gives 1 (auto-retry), and 1x gives 2 (continuous).
- R10: start_done is high for exactly one clock, three clocks after out_charged rises during startup. sw_on stays high at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_above_uv | input | 1 | Supply above undervoltage level |
| in_above_ov | input | 1 | Supply above overvoltage level |
| out_above_uv | input | 1 | Output above its undervoltage level |
| out_charged | input | 1 | Switch drop below the flag threshold |
| en_hv | input | 1 | High-voltage enable pin (active low) |
| en_lv | input | 1 | Low-voltage enable pin (active high) |
| lim_sel | input | 2 | Current-limit mode select pins |
| sw_on | output | 1 | Switch-on request |
| ilim_mult | output | 2 | Current-limit multiplier code |
| start_done | output | 1 | One-cycle startup completion strobe |
| latched_off | output | 1 | Startup-timeout latch status |
| lim_mode | output | 2 | Reported current-limit mode |

## Verification
The bench measures the exact clock on which sw_on rises in four cases: full debounce, skipped debounce, recovery from overvoltage and recovery after a latch clear. A design that counts one tick too many or too few, or that skips the debounce without checking out_above_uv, fails there.

A supply dropout in the middle of the debounce is checked to restart the count. A design that instead resumed the count would switch on early.

The boost window edge, the timeout edge and the latch clear events are each probed one clock before and one clock on the expected edge. The mode pins are held at a non-continuous value throughout startup, so a design that sampled them early would report the wrong mode.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_DEB   = 3'd1,
    ST_GATE  = 3'd2,
    ST_START = 3'd3,
    ST_RUN   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    LIM_LATCH = 2'd0,
    LIM_RETRY = 2'd1,
    LIM_CONT  = 2'd2
  } lim_mode_e;

  localparam logic [1:0] MULT_1X = 2'd0;

  function automatic lim_mode_e decode_mode(input logic [1:0] pins);
    if (pins[1])      return LIM_CONT;
    else if (pins[0]) return LIM_RETRY;
    else              return LIM_LATCH;
  endfunction
endpackage

// File: rtl/psw_sync.sv
module psw_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/psw_qualify.sv
module psw_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_ok,
  input  logic ov_hit,
  input  logic en_hv,
  input  logic en_lv,
  input  logic latch_set,
  output logic qual,
  output logic latched
);
  logic hv_d, lv_d, uv_d, latched_q, clr_evt, en_allowed;

  assign en_allowed = !(en_hv && !en_lv);
  assign clr_evt    = (hv_d != en_hv) || (lv_d != en_lv) || (uv_d && !uv_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv_d      <= 1'b0;
      lv_d      <= 1'b0;
      uv_d      <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      hv_d <= en_hv;
      lv_d <= en_lv;
      uv_d <= uv_ok;
      if (clr_evt)        latched_q <= 1'b0;
      else if (latch_set) latched_q <= 1'b1;
    end
  end

  assign qual    = uv_ok && !ov_hit && en_allowed && !latched_q;
  assign latched = latched_q;
endmodule

// File: rtl/psw_seq_fsm.sv
module psw_seq_fsm #(
  parameter int         DEB_TICKS  = 1200,
  parameter int         GATE_TICKS = 200,
  parameter int         STI_TICKS  = 24000,
  parameter int         STO_TICKS  = 1200000,
  parameter logic [1:0] BOOST_CODE = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qual,
  input  logic       out_uv,
  input  logic       charged,
  input  logic [1:0] sel_pins,
  output logic       sw_on,
  output logic [1:0] ilim_mult,
  output logic       start_done,
  output logic [1:0] lim_mode,
  output logic       latch_set
);
  import psw_pkg::*;

  localparam int MAX_A = (DEB_TICKS > GATE_TICKS) ? DEB_TICKS : GATE_TICKS;
  localparam int MAX_B = (STI_TICKS > STO_TICKS) ? STI_TICKS : STO_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] DEB_LAST  = CW'(DEB_TICKS - 1);
  localparam logic [CW-1:0] GATE_LAST = CW'(GATE_TICKS - 1);
  localparam logic [CW-1:0] STO_LAST  = CW'(STO_TICKS - 1);
  localparam logic [CW-1:0] STI_END   = CW'(STI_TICKS);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          go_run, tmo, done_q;
  lim_mode_e     mode_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + 1'b1;
    go_run = 1'b0;
    tmo    = 1'b0;
    case (st_q)
      ST_OFF: begin
        cnt_d = '0;
        if (qual) st_d = out_uv ? ST_GATE : ST_DEB;
      end
      ST_DEB: begin
        if (!qual) begin
          st_d = ST_OFF; cnt_d = '0;
        end else if (cnt_q == DEB_LAST) begin
          st_d = ST_GATE; cnt_d = '0;
        end
      end
      ST_GATE: begin
        if (!qual) begin
          st_d = ST_OFF; cnt_d = '0;
        end else if (cnt_q == GATE_LAST) begin
          st_d = ST_START; cnt_d = '0;
        end
      end
      ST_START: begin
        if (!qual) begin
          st_d = ST_OFF; cnt_d = '0;
        end else if (charged) begin
          st_d = ST_RUN; go_run = 1'b1; cnt_d = '0;
        end else if (cnt_q == STO_LAST) begin
          st_d = ST_OFF; tmo = 1'b1; cnt_d = '0;
        end
      end
      ST_RUN: begin
        cnt_d = '0;
        if (!qual) st_d = ST_OFF;
      end
      default: begin
        st_d = ST_OFF; cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      cnt_q  <= '0;
      done_q <= 1'b0;
      mode_q <= LIM_CONT;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= go_run;
      if (go_run)             mode_q <= decode_mode(sel_pins);
      else if (st_d != ST_RUN) mode_q <= LIM_CONT;
    end
  end

  assign sw_on      = (st_q == ST_START) || (st_q == ST_RUN);
  assign ilim_mult  = ((st_q == ST_START) && (cnt_q < STI_END)) ? BOOST_CODE : MULT_1X;
  assign start_done = done_q;
  assign lim_mode   = mode_q;
  assign latch_set  = tmo;
endmodule

// File: rtl/psw_start_seq.sv
module psw_start_seq #(
  parameter int         DEB_TICKS  = 1200,
  parameter int         GATE_TICKS = 200,
  parameter int         STI_TICKS  = 24000,
  parameter int         STO_TICKS  = 1200000,
  parameter logic [1:0] BOOST_CODE = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_above_uv,
  input  logic       in_above_ov,
  input  logic       out_above_uv,
  input  logic       out_charged,
  input  logic       en_hv,
  input  logic       en_lv,
  input  logic [1:0] lim_sel,
  output logic       sw_on,
  output logic [1:0] ilim_mult,
  output logic       start_done,
  output logic       latched_off,
  output logic [1:0] lim_mode
);
  localparam int NSYNC = 8;

  logic [NSYNC-1:0] raw_w, syn_w;
  logic             qual_w, latch_set_w;

  assign raw_w = {lim_sel, en_lv, en_hv, out_charged, out_above_uv, in_above_ov, in_above_uv};

  psw_sync #(.WIDTH(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_w), .q(syn_w)
  );

  psw_qualify u_qual (
    .clk(clk), .rst_n(rst_n),
    .uv_ok(syn_w[0]), .ov_hit(syn_w[1]),
    .en_hv(syn_w[4]), .en_lv(syn_w[5]),
    .latch_set(latch_set_w),
    .qual(qual_w), .latched(latched_off)
  );

  psw_seq_fsm #(
    .DEB_TICKS(DEB_TICKS), .GATE_TICKS(GATE_TICKS),
    .STI_TICKS(STI_TICKS), .STO_TICKS(STO_TICKS),
    .BOOST_CODE(BOOST_CODE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .qual(qual_w), .out_uv(syn_w[2]), .charged(syn_w[3]),
    .sel_pins(syn_w[7:6]),
    .sw_on(sw_on), .ilim_mult(ilim_mult), .start_done(start_done),
    .lim_mode(lim_mode), .latch_set(latch_set_w)
  );
endmodule

// File: rtl/psw_start_seq_chk.sv
module psw_start_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       qual,
  input logic       sw_on,
  input logic [1:0] ilim_mult,
  input logic       start_done,
  input logic       latched_off,
  input logic [1:0] lim_mode
);
  AST_OFF_WHEN_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> !sw_on); // R1
  AST_RISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_on) |-> $past(qual)); // R2
  AST_BOOST_ONLY_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_mult != 2'd0) |-> sw_on); // R5
  AST_LATCH_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> !sw_on); // R6
  AST_LATCH_FROM_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_off) |-> $past(sw_on)); // R6
  AST_MODE_CONT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_on |-> (lim_mode == 2'd2)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |=> !start_done); // R10
  AST_DONE_WITH_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |-> sw_on); // R10
endmodule

bind psw_start_seq psw_start_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .qual(qual_w), .sw_on(sw_on),
  .ilim_mult(ilim_mult), .start_done(start_done),
  .latched_off(latched_off), .lim_mode(lim_mode)
);

// File: tb/psw_start_seq_tb.sv
module psw_start_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 8;
  localparam int GATE = 4;
  localparam int STI  = 6;
  localparam int STO  = 40;
  localparam int BOOST = 2;
  localparam int FULL = 3 + DEB + GATE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_above_uv = 0, in_above_ov = 0, out_above_uv = 0, out_charged = 0;
  logic en_hv = 0, en_lv = 0;
  logic [1:0] lim_sel = 2'b00;
  logic sw_on, start_done, latched_off;
  logic [1:0] ilim_mult, lim_mode;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_start_seq #(
    .DEB_TICKS(DEB), .GATE_TICKS(GATE), .STI_TICKS(STI),
    .STO_TICKS(STO), .BOOST_CODE(2'(BOOST))
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_above_uv(in_above_uv), .in_above_ov(in_above_ov),
    .out_above_uv(out_above_uv), .out_charged(out_charged), .en_hv(en_hv), .en_lv(en_lv),
    .lim_sel(lim_sel), .sw_on(sw_on), .ilim_mult(ilim_mult), .start_done(start_done),
    .latched_off(latched_off), .lim_mode(lim_mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    in_above_uv = 0; in_above_ov = 0; out_above_uv = 0; out_charged = 0;
    en_hv = 0; en_lv = 0; lim_sel = 2'b00;
    adv(4);
    rst_n = 1;
    adv(4);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R2 reset sw_on", sw_on, 0);
    chk("R6 reset latched_off", latched_off, 0);
    chk("R5 reset ilim_mult", ilim_mult, 0);
    chk("R10 reset start_done", start_done, 0);
    chk("R9 reset lim_mode", lim_mode, 2);
  endtask

  task automatic t_normal_and_enables();
    do_reset();
    lim_sel = 2'b01;
    in_above_uv = 1;
    adv(FULL - 1);
    chk("R2 off before delay", sw_on, 0);
    adv(1);
    chk("R2 on after delay", sw_on, 1);
    chk("R5 boost at turn-on", ilim_mult, BOOST);
    chk("R9 continuous during startup", lim_mode, 2);
    adv(STI - 1);
    chk("R5 boost last cycle", ilim_mult, BOOST);
    adv(1);
    chk("R5 back to 1x", ilim_mult, 0);
    out_charged = 1;
    adv(2);
    chk("R10 strobe not early", start_done, 0);
    adv(1);
    chk("R10 strobe high", start_done, 1);
    chk("R10 switch kept on", sw_on, 1);
    chk("R9 mode sampled retry", lim_mode, 1);
    adv(1);
    chk("R10 strobe one cycle", start_done, 0);
    en_hv = 1; en_lv = 0;
    adv(2);
    chk("R1 still on before sync", sw_on, 1);
    adv(1);
    chk("R1 off for pair 10", sw_on, 0);
    en_lv = 1;
    adv(FULL - 1);
    chk("R1 pair 11 waits", sw_on, 0);
    adv(1);
    chk("R1 on for pair 11", sw_on, 1);
  endtask

  task automatic t_pair01();
    do_reset();
    en_lv = 1;
    in_above_uv = 1;
    adv(FULL - 1);
    chk("R1 pair 01 waits", sw_on, 0);
    adv(1);
    chk("R1 on for pair 01", sw_on, 1);
  endtask

  task automatic t_uv_abort();
    do_reset();
    in_above_uv = 1;
    adv(3 + DEB / 2);
    in_above_uv = 0;
    adv(3);
    chk("R3 off after dropout", sw_on, 0);
    in_above_uv = 1;
    adv(FULL - 1);
    chk("R3 debounce restarted", sw_on, 0);
    adv(1);
    chk("R3 on after full restart", sw_on, 1);
  endtask

  task automatic t_skip();
    do_reset();
    out_above_uv = 1;
    in_above_uv = 1;
    adv(3 + GATE - 1);
    chk("R4 gate delay only, early", sw_on, 0);
    adv(1);
    chk("R4 on without debounce", sw_on, 1);
    in_above_ov = 1;
    adv(3);
    chk("R4 off in overvoltage", sw_on, 0);
    in_above_ov = 0;
    adv(3 + GATE - 1);
    chk("R4 leaving overvoltage, early", sw_on, 0);
    adv(1);
    chk("R4 on after overvoltage", sw_on, 1);
  endtask

  task automatic t_timeout_clear();
    do_reset();
    in_above_uv = 1;
    adv(FULL);
    chk("R6 startup on", sw_on, 1);
    adv(STO - 1);
    chk("R6 still on before timeout", sw_on, 1);
    chk("R6 not latched before timeout", latched_off, 0);
    adv(1);
    chk("R6 off at timeout", sw_on, 0);
    chk("R6 latched at timeout", latched_off, 1);
    adv(20);
    chk("R6 stays off", sw_on, 0);
    chk("R7 latch holds", latched_off, 1);
    en_lv = 1;
    adv(2);
    chk("R7 latch before clear", latched_off, 1);
    adv(1);
    chk("R7 cleared by enable toggle", latched_off, 0);
    adv(1 + DEB + GATE - 1);
    chk("R7 restart waits", sw_on, 0);
    adv(1);
    chk("R7 restart after clear", sw_on, 1);
    adv(STO);
    chk("R7 latched again", latched_off, 1);
    in_above_uv = 0;
    adv(3);
    chk("R7 cleared by supply dropout", latched_off, 0);
    chk("R7 off while supply low", sw_on, 0);
    in_above_uv = 1;
    adv(FULL);
    chk("R7 on after supply return", sw_on, 1);
  endtask

  task automatic t_restart();
    do_reset();
    lim_sel = 2'b00;
    in_above_uv = 1;
    adv(FULL);
    out_charged = 1;
    adv(3);
    chk("R9 mode sampled latch-off", lim_mode, 0);
    in_above_uv = 0;
    out_charged = 0;
    adv(3);
    chk("R8 off after dropout", sw_on, 0);
    chk("R9 mode continuous after dropout", lim_mode, 2);
    in_above_uv = 1;
    adv(FULL);
    chk("R8 restart on", sw_on, 1);
    adv(STO);
    chk("R8 restart times out", latched_off, 1);
    chk("R8 restart switch off", sw_on, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    t_reset_state();
    t_normal_and_enables();
    t_pair01();
    t_uv_abort();
    t_skip();
    t_timeout_clear();
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule